// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This peripheral holds two reloadable counter channels behind a small word-wide register port. Each channel has a control word, a load value and a live count. A channel counts up or down from its load value to a terminal count. It spends one extra cycle at that terminal count and then reloads, either on its own (auto-reload) or when software asks for it with a load command. Both channels can be started in the same clock by one control write.

When both control words select the pulse mode, the two channels together drive one active-high output. Channel 0's cycle length is the period. Channel 1 is restarted at every period boundary, and its cycle length is the high time. A high time equal to or longer than the period gives a constant low output, so full duty cannot be produced. Software uses the block by writing the two load values, pulsing the load command on both channels, writing the pulse-mode control bits with the counters stopped, and then writing the start-both bit.

The counter width is the parameter `CNT_W`, meant to be 8, 16 or 32. The register addresses are byte offsets. Channel 0 sits at 0x00 (control), 0x04 (load) and 0x08 (count). Channel 1 sits at 0x10, 0x14 and 0x18. Address bit 4 picks the channel and bits 3:2 pick the register.

Top module: `pwmtim_top`

## Requirements
- R1: After reset the output is low, and every control, load and count register reads zero.
- R2: A running channel with control bit 1 (count down) set steps from its load value down to 0. It shows 0 for one more cycle and then reloads, so each cycle lasts load+2 clocks.
- R3: A running channel counting up (bit 1 clear) steps from its load value up to 2^CNT_W-1. It shows that value for one more cycle and then reloads, so each cycle lasts (2^CNT_W-1)-load+2 clocks.
- R4: With control bit 2 (auto-reload) clear, a running channel stops at its terminal count and stays there.
- R5: While control bit 3 (load) is set, the channel copies its load register into its count on every clock, overriding counting.
- R6: A control write with bit 8 set, to either channel, sets bit 0 (run) in both channels at the same clock edge. Bit 8 always reads back as 0.
- R7: A new load value written while a channel runs does not change the cycle in progress. It is used from the next reload onward.
- R8: In pulse mode with high time D shorter than period P, the output stays low until channel 0 first finishes a period. From then on, each P-clock period starts with D high clocks.
- R9: In pulse mode with D greater than or equal to P, the output stays low.
- R10: The output is low in any cycle where any of these fails: bit 0 run, bit 2 auto-reload, bit 4 output enable and bit 5 pulse mode set in both channels, bit 3 load and bit 6 capture clear in both channels, and bit 7 chain clear in channel 0.
- R11: Control bits 7:0 read back as written, the load register reads back as written, and the count register is read-only and returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_we | input | 1 | Write strobe, one word per clock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pwm_o | output | 1 | Pulse output, active high |

## Verification
A counter that steps wrongly, or a terminal-cycle flag stuck in the wrong state, shows up at the count register on the very next clock. A missing or repeated reload cycle shows up within one channel cycle as a count sequence one clock too short or too long. If channel 1 is not restarted at the period boundary, or the high-time decision is wrong, the output waveform goes off at the first full period after start. It is then off on every period after that, so comparing the output each cycle over three periods exposes it. An enable decision that ignores one control bit shows as a high output cycle within one period of setting that bit.

// File: rtl/pwmtim_pkg.sv
`timescale 1ns/1ps
package pwmtim_pkg;
    localparam int DATA_W = 32;
    localparam int CB_ALL = 8;

    // control word bits 7:0, run at bit 0
    typedef struct packed {
        logic chain;
        logic capt;
        logic pwm;
        logic gen;
        logic load;
        logic reload;
        logic down;
        logic run;
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    function automatic logic pwm_ready(ctl_t c, logic chk_chain);
        return c.run && c.reload && c.gen && c.pwm && !c.load && !c.capt
               && !(chk_chain && c.chain);
    endfunction
endpackage

// File: rtl/pwmtim_chan.sv
`timescale 1ns/1ps
module pwmtim_chan
    import pwmtim_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_ctl,
    input  ctl_t         ctl_in,
    input  logic         wr_load,
    input  logic [W-1:0] load_in,
    input  logic         start_all,
    input  logic         restart,
    output ctl_t         ctl_o,
    output logic [W-1:0] load_o,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic [W+1:0] len_o
);
    localparam logic [W+1:0] MAXV = {2'b00, {W{1'b1}}};
    localparam logic [W+1:0] TWO  = (W+2)'(2);

    ctl_t         ctl_q, ctl_n;
    logic [W-1:0] load_q, cnt_q, term;
    logic         wrap_q;

    always_comb begin
        ctl_n = wr_ctl ? ctl_in : ctl_q;
        if (start_all) ctl_n.run = 1'b1;
    end

    assign term = ctl_q.down ? '0 : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            load_q <= '0;
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            ctl_q <= ctl_n;
            if (wr_load) load_q <= load_in;
            if (ctl_q.load || restart) begin
                cnt_q  <= load_q;
                wrap_q <= 1'b0;
            end else if (ctl_q.run) begin
                if (wrap_q) begin
                    cnt_q  <= load_q;
                    wrap_q <= 1'b0;
                end else if (cnt_q == term) begin
                    wrap_q <= ctl_q.reload;
                end else if (ctl_q.down) begin
                    cnt_q <= cnt_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign ctl_o  = ctl_q;
    assign load_o = load_q;
    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;
    assign len_o  = ctl_q.down ? ({2'b00, load_q} + TWO)
                               : (MAXV - {2'b00, load_q} + TWO);

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        ctl_q.load |=> cnt_q == $past(load_q)); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !ctl_q.load && !restart && !wrap_q && cnt_q != term)
        |=> cnt_q == ($past(ctl_q.down) ? $past(cnt_q) - 1'b1 : $past(cnt_q) + 1'b1)); // R2

    AST_HOLD_TERM: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !ctl_q.load && !restart && !ctl_q.reload && !wrap_q && cnt_q == term)
        |=> cnt_q == $past(cnt_q) && !wrap_q); // R4

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && ctl_q.run && !ctl_q.load && !restart)
        |=> cnt_q == $past(load_q) && !wrap_q); // R7
endmodule

// File: rtl/pwmtim_wave.sv
`timescale 1ns/1ps
module pwmtim_wave #(
    parameter int LW = 34
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          end0,
    input  logic          end1,
    input  logic [LW-1:0] len0,
    input  logic [LW-1:0] len1,
    output logic          pwm_o
);
    logic high_q;

    always_ff @(posedge clk) begin
        if (rst || !active) high_q <= 1'b0;
        else if (end0)      high_q <= (len1 < len0);
        else if (end1)      high_q <= 1'b0;
    end

    assign pwm_o = high_q && active;

    AST_RISE_AT_ROLL: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_o) |-> $past(end0)); // R8

    AST_DUTY_END: assert property (@(posedge clk) disable iff (rst)
        (active && end1 && !end0) |=> !pwm_o); // R8

    AST_NO_FULL_DUTY: assert property (@(posedge clk) disable iff (rst)
        (active && end0 && !(len1 < len0)) |=> !pwm_o); // R9
endmodule

// File: rtl/pwmtim_top.sv
`timescale 1ns/1ps
module pwmtim_top
    import pwmtim_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_o
);
    localparam int NCH = 2;
    localparam int LW  = CNT_W + 2;

    logic             ch_sel;
    sel_e             sel;
    logic             start_all, active, restart_w;
    ctl_t             ctl_w  [NCH];
    logic [CNT_W-1:0] load_w [NCH];
    logic [CNT_W-1:0] cnt_w  [NCH];
    logic             wrap_w [NCH];
    logic [LW-1:0]    len_w  [NCH];
    logic             unused_bits;

    assign ch_sel      = reg_addr[4];
    assign sel         = sel_e'(reg_addr[3:2]);
    assign start_all   = reg_we && sel == SEL_CTL && reg_wdata[CB_ALL];
    assign unused_bits = ^{reg_addr, reg_wdata};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwmtim_chan #(.W(CNT_W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_ctl    (reg_we && sel == SEL_CTL && ch_sel == 1'(g)),
            .ctl_in    (ctl_t'(reg_wdata[7:0])),
            .wr_load   (reg_we && sel == SEL_LOAD && ch_sel == 1'(g)),
            .load_in   (reg_wdata[CNT_W-1:0]),
            .start_all (start_all),
            .restart   ((g == 1) ? restart_w : 1'b0),
            .ctl_o     (ctl_w[g]),
            .load_o    (load_w[g]),
            .cnt_o     (cnt_w[g]),
            .wrap_o    (wrap_w[g]),
            .len_o     (len_w[g])
        );
    end

    assign active    = pwm_ready(ctl_w[0], 1'b1) && pwm_ready(ctl_w[1], 1'b0);
    assign restart_w = active && wrap_w[0];

    pwmtim_wave #(.LW(LW)) u_wave (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .end0   (wrap_w[0]),
        .end1   (wrap_w[1]),
        .len0   (len_w[0]),
        .len1   (len_w[1]),
        .pwm_o  (pwm_o)
    );

    always_comb begin
        case (sel)
            SEL_CTL:  reg_rdata = {24'd0, ctl_w[ch_sel]};
            SEL_LOAD: reg_rdata = 32'(load_w[ch_sel]);
            SEL_CNT:  reg_rdata = 32'(cnt_w[ch_sel]);
            default:  reg_rdata = '0;
        endcase
    end

    AST_START_BOTH: assert property (@(posedge clk) disable iff (rst)
        start_all |=> ctl_w[0].run && ctl_w[1].run); // R6
endmodule

// File: tb/pwmtim_top_bench.sv
`timescale 1ns/1ps
module pwmtim_top_bench;
    localparam int CLK_P = 10;
    localparam logic [4:0] A_C0 = 5'h00, A_L0 = 5'h04, A_N0 = 5'h08;
    localparam logic [4:0] A_C1 = 5'h10, A_L1 = 5'h14, A_N1 = 5'h18;
    localparam logic [31:0] B_RUN = 32'h1, B_DOWN = 32'h2, B_REL = 32'h4, B_LOAD = 32'h8;
    localparam logic [31:0] B_GEN = 32'h10, B_PWM = 32'h20, B_CHAIN = 32'h80;
    localparam logic [31:0] B_ALL = 32'h100;
    localparam logic [31:0] BASE = B_DOWN | B_REL | B_GEN | B_PWM;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pwm_o;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic        exp_q[$];
    string       tag_q[$];

    pwmtim_top u_pwmtim_top (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // monitor: compares the output against queued expectations, mid-cycle
    always @(posedge clk) begin : mon
        logic  e;
        string t;
        #(CLK_P/4);
        if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {31'd0, pwm_o}, {31'd0, e});
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk_rd(string tag, logic [4:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic chk_cnt(string tag, logic [4:0] a, logic [31:0] exp);
        chk_rd(tag, a, exp);
        @(negedge clk);
    endtask

    task automatic push(logic v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // start pulse mode with down counters and queue nper periods of output
    task automatic pwm_run(int l0, int l1, int nper, string tag);
        int p, d;
        p = l0 + 2;
        d = l1 + 2;
        wr(A_C0, 32'd0); wr(A_C1, 32'd0);
        wr(A_L0, 32'(l0)); wr(A_L1, 32'(l1));
        wr(A_C0, B_DOWN | B_LOAD); wr(A_C1, B_DOWN | B_LOAD);
        wr(A_C0, BASE);
        for (int i = 0; i < p; i++) push(1'b0, tag);
        for (int k = 0; k < nper; k++)
            for (int i = 0; i < p; i++) push((d < p) && (i < d), tag);
        wr(A_C1, BASE | B_ALL);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pwm", {31'd0, pwm_o}, 32'd0);
        chk_rd("R1 ctl0", A_C0, 32'd0);
        chk_rd("R1 load1", A_L1, 32'd0);
        chk_rd("R1 cnt1", A_N1, 32'd0);

        // R2 down count, load 5: 7-clock cycle
        wr(A_L0, 32'd5); wr(A_C0, B_DOWN | B_LOAD); wr(A_C0, B_DOWN | B_REL | B_RUN);
        chk_rd("R11 ctl readback", A_C0, B_DOWN | B_REL | B_RUN);
        chk_rd("R11 load readback", A_L0, 32'd5);
        chk_cnt("R2", A_N0, 5); chk_cnt("R2", A_N0, 4); chk_cnt("R2", A_N0, 3);
        chk_cnt("R2", A_N0, 2); chk_cnt("R2", A_N0, 1); chk_cnt("R2", A_N0, 0);
        chk_cnt("R2", A_N0, 0); chk_cnt("R2", A_N0, 5); chk_cnt("R2", A_N0, 4);
        wr(A_C0, 32'd0);

        // R7 new load while running applies from next reload
        wr(A_L0, 32'd6); wr(A_C0, B_DOWN | B_LOAD); wr(A_C0, B_DOWN | B_REL | B_RUN);
        wr(A_L0, 32'd2);
        chk_cnt("R7", A_N0, 5); chk_cnt("R7", A_N0, 4); chk_cnt("R7", A_N0, 3);
        chk_cnt("R7", A_N0, 2); chk_cnt("R7", A_N0, 1); chk_cnt("R7", A_N0, 0);
        chk_cnt("R7", A_N0, 0); chk_cnt("R7", A_N0, 2); chk_cnt("R7", A_N0, 1);
        chk_cnt("R7", A_N0, 0); chk_cnt("R7", A_N0, 0); chk_cnt("R7", A_N0, 2);
        wr(A_C0, 32'd0);

        // R4 no auto-reload: holds at terminal
        wr(A_L0, 32'd2); wr(A_C0, B_DOWN | B_LOAD); wr(A_C0, B_DOWN | B_RUN);
        chk_cnt("R4", A_N0, 2); chk_cnt("R4", A_N0, 1); chk_cnt("R4", A_N0, 0);
        chk_cnt("R4", A_N0, 0); chk_cnt("R4", A_N0, 0); chk_cnt("R4", A_N0, 0);
        wr(A_C0, 32'd0);

        // R3 up count on channel 1, terminal at all ones
        wr(A_L1, 32'hFFFF_FFFC); wr(A_C1, B_LOAD); wr(A_C1, B_REL | B_RUN);
        chk_cnt("R3", A_N1, 32'hFFFF_FFFC); chk_cnt("R3", A_N1, 32'hFFFF_FFFD);
        chk_cnt("R3", A_N1, 32'hFFFF_FFFE); chk_cnt("R3", A_N1, 32'hFFFF_FFFF);
        chk_cnt("R3", A_N1, 32'hFFFF_FFFF); chk_cnt("R3", A_N1, 32'hFFFF_FFFC);
        chk_cnt("R3", A_N1, 32'hFFFF_FFFD);
        wr(A_C1, 32'd0);

        // R5 load bit copies load register each clock
        wr(A_C0, B_LOAD);
        wr(A_L0, 32'd77);
        chk_cnt("R5 before copy", A_N0, 2);
        chk_cnt("R5 copied", A_N0, 77);
        wr(A_L0, 32'd40);
        @(negedge clk);
        chk_rd("R5 recopied", A_N0, 40);

        // R11 count register is read-only
        wr(A_C0, 32'd0);
        wr(A_N0, 32'd123);
        chk_rd("R11 count write ignored", A_N0, 40);

        // R6 start both channels from one write
        wr(A_L0, 32'd6); wr(A_L1, 32'd9);
        wr(A_C0, B_DOWN | B_LOAD); wr(A_C1, B_DOWN | B_LOAD);
        wr(A_C0, B_DOWN | B_REL);
        wr(A_C1, B_DOWN | B_REL | B_ALL);
        chk_rd("R6 ctl0 run", A_C0, B_DOWN | B_REL | B_RUN);
        chk_rd("R6 ctl1 run", A_C1, B_DOWN | B_REL | B_RUN);
        chk_rd("R6 cnt0", A_N0, 6);
        chk_rd("R6 cnt1", A_N1, 9);
        @(negedge clk);
        chk_rd("R6 cnt0 step", A_N0, 5);
        chk_rd("R6 cnt1 step", A_N1, 8);

        // R8 waveform, R9 constant low
        pwm_run(6, 1, 3, "R8 P8 D3");
        pwm_run(10, 4, 3, "R8 P12 D6");
        pwm_run(6, 6, 3, "R9 D=P");
        pwm_run(6, 9, 3, "R9 D>P");

        // R10 chain bit on channel 0 forces low
        pwm_run(6, 1, 1, "R8 pre R10");
        for (int i = 0; i < 16; i++) push(1'b0, "R10 chain");
        wr(A_C0, BASE | B_RUN | B_CHAIN);
        drain();
        wr(A_C0, BASE | B_RUN);
        repeat (4) @(negedge clk);
        // R10 output enable cleared on channel 1 forces low
        for (int i = 0; i < 16; i++) push(1'b0, "R10 gen off");
        wr(A_C1, B_DOWN | B_REL | B_PWM | B_RUN);
        drain();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule